// File: doc/BRIEF.md
# Fail-Safe System Clock Selector

This block picks the source for four clock outputs of a system: an auxiliary clock, a main clock, a sub-main clock and an undivided reference for the frequency-locked loop. Six oscillators feed it: a low-frequency crystal, a very-low-power internal oscillator, an internal 32 kHz reference, the DCO, a high-frequency crystal and a second crystal. Each oscillator is modelled as a one-cycle tick enable on the system clock, and each output is also a tick enable. A second DCO source, the DCO divided by two, is derived inside the block. Each of the three system outputs adds a power-of-two divider.

A sticky fault flag supervises each oscillator. A crystal whose flag is set is replaced by a fallback for every output that selects it. The low-frequency crystal falls back to the internal reference, and both high-frequency crystals fall back to the DCO. Crystals start up faulted. Software clears the flags once the oscillators are stable, and the programmed selection then returns. Peripheral clock requests for the main or sub-main clock veto a low-power request.

There is no streaming data path. All pins are plain control and status levels or single-cycle pulses, so no valid/ready back-pressure applies.

Top module: `fail_safe_clk_sel`

## Requirements
- R1: After reset the auxiliary and reference channels select the low-frequency crystal (code 0), the main and sub-main channels select DCO/2 (code 4), and all dividers are 1. A write with `cfg_we` high stores `cfg_src` and `cfg_div` for channel `cfg_chan`, where 0 is auxiliary, 1 is main, 2 is sub-main and 3 is reference.
- R2: After reset the fault flags read 4'b1110. The bit order is 0 DCO, 1 low-frequency crystal, 2 high-frequency crystal, 3 second crystal.
- R3: A high `fault_in[i]` sets `fault_flag[i]` at the next clock edge. The flag then holds when the input drops.
- R4: A `fault_clr[i]` pulse while `fault_in[i]` is low clears the flag at the next edge. While `fault_in[i]` is high the pulse has no effect.
- R5: `fault_any` is high exactly when any fault flag is set.
- R6: While flag 1 is set, a channel programmed to the low-frequency crystal counts internal-reference ticks (`osc_tick[2]`).
- R7: While flag 2 or flag 3 is set, a channel programmed to that crystal counts DCO ticks (`osc_tick[3]`). A set DCO flag causes no substitution.
- R8: Source codes are 0 low-frequency crystal (`osc_tick[0]`), 1 very-low-power oscillator (`osc_tick[1]`), 2 internal reference (`osc_tick[2]`), 3 DCO (`osc_tick[3]`), 4 DCO/2, 5 high-frequency crystal (`osc_tick[4]`), 6 second crystal (`osc_tick[5]`). Code 7 behaves as code 4. DCO/2 passes every second DCO tick, starting with the second tick after reset.
- R9: For a divider code d, a system channel emits one output tick for every 2^min(d,5) source ticks. The tick appears one cycle after the source tick that completes the count.
- R10: A new source or divider takes effect only once the channel's divide counter is zero. Ticks still needed to finish the current period come from the old source.
- R11: `lp_grant` is registered. It is high one cycle after `lp_req` is high while no bit of `req_main` or `req_sub` is set, and low otherwise.
- R12: The reference channel is never divided. Its `cfg_div` field is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 6 | Oscillator tick enables |
| fault_in | input | 4 | Raw oscillator fault indications |
| fault_clr | input | 4 | Fault flag clear pulses |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 2 | Channel written |
| cfg_src | input | 3 | Source code written |
| cfg_div | input | 3 | Divider log2 code written |
| req_main | input | NREQ | Peripheral requests for the main clock |
| req_sub | input | NREQ | Peripheral requests for the sub-main clock |
| lp_req | input | 1 | Deep low-power entry request |
| aux_tick | output | 1 | Auxiliary clock tick |
| main_tick | output | 1 | Main clock tick |
| sub_tick | output | 1 | Sub-main clock tick |
| ref_tick | output | 1 | Loop reference tick |
| fault_flag | output | 4 | Sticky fault flags |
| fault_any | output | 1 | Global oscillator fault |
| lp_grant | output | 1 | Low-power entry granted |

## Verification
The bench runs every source code against every divider code, with each oscillator ticking at its own rate, so a swapped source or a wrong divider shows up as a wrong tick count. It starts from the reset state with faulted crystals. A design that ignored the flags or used raw fault inputs would count crystal ticks there instead of fallback ticks, and a design that let the DCO flag substitute would lose the DCO count. It also changes the source halfway through a divide period. A selector that switched at once would drop the old source's remaining ticks and miss the pending output tick. A clear issued while the fault is still present must leave the flag set.

// File: rtl/csel_pkg.sv
package csel_pkg;

  typedef enum logic [2:0] {
    SRC_LF   = 3'd0,
    SRC_VLO  = 3'd1,
    SRC_IREF = 3'd2,
    SRC_DCO  = 3'd3,
    SRC_DCOH = 3'd4,
    SRC_HF   = 3'd5,
    SRC_XT2  = 3'd6,
    SRC_RSV  = 3'd7
  } src_e;

  localparam int NSRC = 8;
  localparam int NOSC = 6;
  localparam int NFLT = 4;
  localparam int NCH  = 4;

  localparam int FLT_DCO = 0;
  localparam int FLT_LF  = 1;
  localparam int FLT_HF  = 2;
  localparam int FLT_XT2 = 3;

  localparam int CH_AUX  = 0;
  localparam int CH_MAIN = 1;
  localparam int CH_SUB  = 2;
  localparam int CH_REF  = 3;

  localparam logic [NFLT-1:0] FLT_RESET = 4'b1110;

  function automatic src_e reset_sel(int ch);
    if (ch == CH_MAIN || ch == CH_SUB) return SRC_DCOH;
    return SRC_LF;
  endfunction

  function automatic src_e resolve_src(src_e s, logic [NFLT-1:0] flg);
    case (s)
      SRC_LF:  return flg[FLT_LF]  ? SRC_IREF : SRC_LF;
      SRC_HF:  return flg[FLT_HF]  ? SRC_DCO  : SRC_HF;
      SRC_XT2: return flg[FLT_XT2] ? SRC_DCO  : SRC_XT2;
      SRC_RSV: return SRC_DCOH;
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/csel_src_prep.sv
module csel_src_prep
  import csel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NOSC-1:0] osc_tick,
  output logic [NSRC-1:0] src_tick
);

  logic half_q;
  logic dcoh;

  always_ff @(posedge clk) begin
    if (!rst_n)           half_q <= 1'b0;
    else if (osc_tick[3]) half_q <= ~half_q;
  end

  assign dcoh = osc_tick[3] & half_q;

  always_comb begin
    src_tick           = '0;
    src_tick[SRC_LF]   = osc_tick[0];
    src_tick[SRC_VLO]  = osc_tick[1];
    src_tick[SRC_IREF] = osc_tick[2];
    src_tick[SRC_DCO]  = osc_tick[3];
    src_tick[SRC_DCOH] = dcoh;
    src_tick[SRC_HF]   = osc_tick[4];
    src_tick[SRC_XT2]  = osc_tick[5];
    src_tick[SRC_RSV]  = dcoh;
  end

endmodule

// File: rtl/csel_fault_bank.sv
module csel_fault_bank #(
  parameter int              NF        = 4,
  parameter logic [NF-1:0]   RST_FLAGS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] fault_in,
  input  logic [NF-1:0] fault_clr,
  output logic [NF-1:0] flags,
  output logic          any
);

  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (!rst_n)           f_q <= RST_FLAGS[i];
      else if (fault_in[i]) f_q <= 1'b1;
      else if (fault_clr[i]) f_q <= 1'b0;
    end
    assign flags[i] = f_q;
  end

  assign any = |flags;

endmodule

// File: rtl/csel_div_chan.sv
module csel_div_chan
  import csel_pkg::*;
#(
  parameter int   LOGW    = 3,
  parameter int   LOG_MAX = 5,
  parameter src_e RST_SRC = SRC_LF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  src_e            want_src,
  input  logic [LOGW-1:0] want_log,
  output logic            out_tick
);

  localparam int CW = LOG_MAX;

  src_e            cur_src;
  logic [LOGW-1:0] cur_log;
  logic [LOGW-1:0] sat_log;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   lim;
  logic            hit;
  logic            at_zero;

  assign sat_log = (want_log > LOGW'(LOG_MAX)) ? LOGW'(LOG_MAX) : want_log;
  assign lim     = ~({CW{1'b1}} << cur_log);
  assign hit     = src_tick[cur_src];
  assign at_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_src <= RST_SRC;
      cur_log <= '0;
    end else if (at_zero) begin
      cur_src <= want_src;
      cur_log <= sat_log;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      out_tick <= 1'b0;
    end else if (hit) begin
      if (cnt == lim) begin
        cnt      <= '0;
        out_tick <= 1'b1;
      end else begin
        cnt      <= cnt + 1'b1;
        out_tick <= 1'b0;
      end
    end else begin
      out_tick <= 1'b0;
    end
  end

endmodule

// File: rtl/csel_lp_gate.sv
module csel_lp_gate #(
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lp_req,
  input  logic [NREQ-1:0] req_main,
  input  logic [NREQ-1:0] req_sub,
  output logic            lp_grant
);

  logic veto;

  assign veto = (|req_main) | (|req_sub);

  always_ff @(posedge clk) begin
    if (!rst_n) lp_grant <= 1'b0;
    else        lp_grant <= lp_req & ~veto;
  end

endmodule

// File: rtl/fail_safe_clk_sel.sv
module fail_safe_clk_sel
  import csel_pkg::*;
#(
  parameter int NREQ    = 4,
  parameter int LOG_MAX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      osc_tick,
  input  logic [3:0]      fault_in,
  input  logic [3:0]      fault_clr,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_chan,
  input  logic [2:0]      cfg_src,
  input  logic [2:0]      cfg_div,
  input  logic [NREQ-1:0] req_main,
  input  logic [NREQ-1:0] req_sub,
  input  logic            lp_req,
  output logic            aux_tick,
  output logic            main_tick,
  output logic            sub_tick,
  output logic            ref_tick,
  output logic [3:0]      fault_flag,
  output logic            fault_any,
  output logic            lp_grant
);

  localparam int LOGW = 3;

  logic [NSRC-1:0] src_tick;
  logic [NCH-1:0]  chan_tick;

  csel_src_prep u_prep (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .src_tick (src_tick)
  );

  csel_fault_bank #(
    .NF        (NFLT),
    .RST_FLAGS (FLT_RESET)
  ) u_faults (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_in  (fault_in),
    .fault_clr (fault_clr),
    .flags     (fault_flag),
    .any       (fault_any)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam src_e RST_SRC = reset_sel(c);

    logic [2:0]      sel_q;
    logic [LOGW-1:0] log_q;
    src_e            want;
    logic            wr;

    assign wr = cfg_we && (cfg_chan == 2'(c));

    always_ff @(posedge clk) begin
      if (!rst_n)  sel_q <= RST_SRC;
      else if (wr) sel_q <= cfg_src;
    end

    if (c == CH_REF) begin : g_nodiv
      assign log_q = '0;
    end else begin : g_div
      always_ff @(posedge clk) begin
        if (!rst_n)  log_q <= '0;
        else if (wr) log_q <= cfg_div;
      end
    end

    assign want = resolve_src(src_e'(sel_q), fault_flag);

    csel_div_chan #(
      .LOGW    (LOGW),
      .LOG_MAX (LOG_MAX),
      .RST_SRC (RST_SRC)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .want_src (want),
      .want_log (log_q),
      .out_tick (chan_tick[c])
    );
  end

  assign aux_tick  = chan_tick[CH_AUX];
  assign main_tick = chan_tick[CH_MAIN];
  assign sub_tick  = chan_tick[CH_SUB];
  assign ref_tick  = chan_tick[CH_REF];

  csel_lp_gate #(.NREQ(NREQ)) u_lp (
    .clk      (clk),
    .rst_n    (rst_n),
    .lp_req   (lp_req),
    .req_main (req_main),
    .req_sub  (req_sub),
    .lp_grant (lp_grant)
  );

endmodule

// File: rtl/csel_checker.sv
module csel_checker #(
  parameter int NREQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [5:0]      osc_tick,
  input logic [3:0]      fault_in,
  input logic [3:0]      fault_clr,
  input logic [NREQ-1:0] req_main,
  input logic [NREQ-1:0] req_sub,
  input logic            lp_req,
  input logic            aux_tick,
  input logic            main_tick,
  input logic            sub_tick,
  input logic            ref_tick,
  input logic [3:0]      fault_flag,
  input logic            lp_grant
);

  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_in) |=> ((fault_flag & $past(fault_in)) == $past(fault_in)));

  // R4
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fault_clr & ~fault_in)) |=> ((fault_flag & $past(fault_clr & ~fault_in)) == 4'b0));

  // R11
  lp_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_main) || (|req_sub)) |=> !lp_grant);

  // R11
  lp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_req |=> !lp_grant);

  // R9
  tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_tick || main_tick || sub_tick || ref_tick) |-> $past(|osc_tick));

endmodule

bind fail_safe_clk_sel csel_checker #(.NREQ(NREQ)) i_csel_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .osc_tick   (osc_tick),
  .fault_in   (fault_in),
  .fault_clr  (fault_clr),
  .req_main   (req_main),
  .req_sub    (req_sub),
  .lp_req     (lp_req),
  .aux_tick   (aux_tick),
  .main_tick  (main_tick),
  .sub_tick   (sub_tick),
  .ref_tick   (ref_tick),
  .fault_flag (fault_flag),
  .lp_grant   (lp_grant)
);

// File: tb/test_fail_safe_clk_sel.sv
`timescale 1ns/1ps
module test_fail_safe_clk_sel;

  localparam int NREQ = 4;
  localparam int SLOTS = 768;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [5:0]      osc_tick;
  logic [3:0]      fault_in;
  logic [3:0]      fault_clr;
  logic            cfg_we;
  logic [1:0]      cfg_chan;
  logic [2:0]      cfg_src;
  logic [2:0]      cfg_div;
  logic [NREQ-1:0] req_main;
  logic [NREQ-1:0] req_sub;
  logic            lp_req;
  logic            aux_tick, main_tick, sub_tick, ref_tick;
  logic [3:0]      fault_flag;
  logic            fault_any;
  logic            lp_grant;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int n_tick [4];
  int bsel [4];
  int blog [4];
  logic [3:0] bflag;

  always #2.5 clk = ~clk;

  fail_safe_clk_sel #(.NREQ(NREQ)) i_fail_safe_clk_sel (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .fault_in(fault_in),
    .fault_clr(fault_clr), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_src(cfg_src), .cfg_div(cfg_div), .req_main(req_main),
    .req_sub(req_sub), .lp_req(lp_req), .aux_tick(aux_tick),
    .main_tick(main_tick), .sub_tick(sub_tick), .ref_tick(ref_tick),
    .fault_flag(fault_flag), .fault_any(fault_any), .lp_grant(lp_grant)
  );

  always @(negedge clk) begin
    if (aux_tick)  n_tick[0]++;
    if (main_tick) n_tick[1]++;
    if (sub_tick)  n_tick[2]++;
    if (ref_tick)  n_tick[3]++;
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // source code after fallback, from R6 R7 R8
  function automatic int eff_src(int s, logic [3:0] f);
    if (s == 0 && f[1]) return 2;
    if (s == 5 && f[2]) return 3;
    if (s == 6 && f[3]) return 3;
    if (s == 7) return 4;
    return s;
  endfunction

  // ticks per phase for each source code, from the phase tick schedule
  function automatic int src_count(int e);
    case (e)
      0: return SLOTS / 2;
      1: return SLOTS / 4;
      2: return SLOTS;
      3: return SLOTS / 3;
      4: return SLOTS / 6;
      5: return SLOTS / 8;
      6: return SLOTS / 12;
      default: return SLOTS / 6;
    endcase
  endfunction

  function automatic int expect_ticks(int c);
    int lg;
    lg = (c == 3) ? 0 : ((blog[c] > 5) ? 5 : blog[c]);
    return src_count(eff_src(bsel[c], bflag)) >> lg;
  endfunction

  task automatic cfg(int ch, int s, int d);
    cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_src = 3'(s); cfg_div = 3'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    bsel[ch] = s;
    if (ch != 3) blog[ch] = d;
  endtask

  task automatic run_phase();
    repeat (2) @(negedge clk);
    for (int c = 0; c < 4; c++) n_tick[c] = 0;
    for (int k = 0; k < SLOTS; k++) begin
      osc_tick[0] = (k % 2) == 0;
      osc_tick[1] = (k % 4) == 0;
      osc_tick[2] = 1'b1;
      osc_tick[3] = (k % 3) == 0;
      osc_tick[4] = (k % 8) == 0;
      osc_tick[5] = (k % 12) == 0;
      @(negedge clk);
    end
    osc_tick = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(string req);
    for (int c = 0; c < 4; c++) chk(req, n_tick[c], expect_ticks(c));
  endtask

  task automatic pulse_src(int idx, int n);
    for (int c = 0; c < 4; c++) n_tick[c] = 0;
    for (int k = 0; k < n; k++) begin
      osc_tick = '0;
      osc_tick[idx] = 1'b1;
      @(negedge clk);
    end
    osc_tick = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; osc_tick = '0; fault_in = '0; fault_clr = '0;
    cfg_we = 1'b0; cfg_chan = '0; cfg_src = '0; cfg_div = '0;
    req_main = '0; req_sub = '0; lp_req = 1'b0;
    bsel = '{0, 4, 4, 0}; blog = '{0, 0, 0, 0}; bflag = 4'b1110;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R5 reset state
    chk("R2", int'(fault_flag), 14);
    chk("R5", int'(fault_any), 1);
    chk("R11", int'(lp_grant), 0);

    // R1 R6 defaults with faulted crystals at startup
    run_phase();
    check_all("R1 R6");

    // R4 clear while fault active has no effect
    fault_in[1] = 1'b1; fault_clr = 4'b0010;
    @(negedge clk);
    fault_clr = '0;
    @(negedge clk);
    chk("R4", int'(fault_flag[1]), 1);
    fault_in = '0;
    repeat (2) @(negedge clk);
    chk("R3", int'(fault_flag), 14);
    fault_clr = 4'b1111;
    @(negedge clk);
    fault_clr = '0;
    bflag = '0;
    chk("R4", int'(fault_flag), 0);
    chk("R5", int'(fault_any), 0);

    // R8 R9 R12 sweep of all source and divider codes
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 8; d++) begin
        cfg(0, s, d);
        cfg(1, (s + 3) % 8, (d + 2) % 8);
        cfg(2, (s + 5) % 8, (d + 5) % 8);
        cfg(3, (s + 1) % 8, d);
        run_phase();
        check_all("R8 R9 R12");
      end
    end

    // R3 R6 R7 crystal faults and fallback
    fault_in = 4'b1110;
    @(negedge clk);
    fault_in = '0;
    @(negedge clk);
    chk("R3", int'(fault_flag), 14);
    bflag = 4'b1110;
    cfg(0, 0, 0); cfg(1, 5, 1); cfg(2, 6, 2); cfg(3, 5, 0);
    run_phase();
    check_all("R6 R7");

    // R7 R5 DCO flag does not substitute
    fault_in = 4'b0001;
    @(negedge clk);
    fault_in = '0;
    @(negedge clk);
    chk("R5", int'(fault_any), 1);
    chk("R3", int'(fault_flag[0]), 1);
    bflag = 4'b1111;
    cfg(2, 3, 0);
    run_phase();
    check_all("R7");

    // R4 clearing restores programmed selection
    fault_clr = 4'b1111;
    @(negedge clk);
    fault_clr = '0;
    bflag = '0;
    run_phase();
    check_all("R4 R6");

    // R10 switch waits for the divide counter to reach zero
    cfg(0, 2, 5);
    repeat (2) @(negedge clk);
    pulse_src(2, 16);
    chk("R10", n_tick[0], 0);
    cfg(0, 0, 5);
    repeat (2) @(negedge clk);
    pulse_src(2, 16);
    chk("R10", n_tick[0], 1);
    pulse_src(0, 32);
    chk("R10", n_tick[0], 1);

    // R11 low-power grant and vetoes
    lp_req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11", int'(lp_grant), 1);
    req_sub[2] = 1'b1;
    @(negedge clk);
    chk("R11", int'(lp_grant), 0);
    req_sub = '0; req_main[0] = 1'b1;
    @(negedge clk);
    chk("R11", int'(lp_grant), 0);
    req_main = '0;
    @(negedge clk);
    chk("R11", int'(lp_grant), 1);
    lp_req = 1'b0;
    @(negedge clk);
    chk("R11", int'(lp_grant), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule